// File: doc/BRIEF.md
# Quadrature Direct Digital Frequency Synthesizer

This block is a frequency-agile digital sinewave source. It serves as the local oscillator of a frequency-hopping radio. An 11-bit tuning word sets how far the phase moves on each sample clock, and an 11-bit phase register adds that step every cycle. The upper bits of the phase address two quarter-wave tables, one for sine and one for cosine. Together they give an in-phase (I) and a quadrature (Q) sample on every clock. Both samples are 10-bit two's complement words, registered, and ready for a pair of DACs.

A single sideband control negates the Q output. With Q negated, the analog quadrature up-converter that follows adds or subtracts its two products, so the radio lands above or below the carrier. A new tuning word is taken on a load strobe and applies from the next accumulation cycle. The phase is never disturbed, so a hop is immediate and phase-continuous. The phase adder is split into a carry-select structure so that the accumulation loop stays short at a high sample rate.

Top module: `quad_dds`

## Requirements
- R1: While `rst` is high at a rising edge, `i_out` and `q_out` become 0, the phase register becomes 0 and the stored tuning word becomes 0.
- R2: `fcw_in` is stored only at a rising edge where `fcw_load` is high. At every other edge, changes on `fcw_in` have no effect on the outputs.
- R3: At each rising edge out of reset, the phase advances by the stored tuning word modulo 2048. A stored word of 0 freezes the phase, so the outputs stay constant.
- R4: `i_out` equals round(511·sin(2π(p+0.5)/512)), with the magnitude rounded half-up and the sign applied afterwards. Here p is bits [10:2] of the phase held before that edge.
- R5: When `sb_lower` is 0 at the edge, `q_out` equals the same expression with cos in place of sin, using the same p.
- R6: When `sb_lower` is 1 at the edge, `q_out` is the two's complement negation of the R5 value, and `i_out` is unchanged from what R4 gives.
- R7: A word loaded at edge E is first added at edge E+1. The outputs at edge E+2 are the first to reflect it.
- R8: Loading a new word never resets or jumps the phase; the accumulated phase carries on from its current value.
- R9: Neither output ever takes the value -512; every sample lies in [-511, 511].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_load | input | 1 | Strobe that stores `fcw_in` |
| fcw_in | input | 11 | Phase increment per sample |
| sb_lower | input | 1 | 1 negates Q (lower sideband), 0 passes it (upper sideband) |
| i_out | output | 10 | In-phase sample, two's complement |
| q_out | output | 10 | Quadrature sample, two's complement |

## Verification
The bench targets quadrant boundaries and full phase wrap. It sweeps a tuning word of 1 across all 2048 phases and steps backwards with 2047. A table mirrored on the wrong index or negated in the wrong quadrant would give a sign flip or a one-entry offset right at those transitions. It also checks the one-cycle gap between a load strobe and its effect, and it drives changes on the unstrobed word input. A design that applies the word a cycle early, or that lets the raw input leak through, would drift off the expected phase. Hops every few cycles and a per-cycle sideband toggle expose any phase reset on load and any negation of the wrong channel or on the wrong cycle.

// File: rtl/quad_dds_pkg.sv
package quad_dds_pkg;

  typedef enum logic {SB_UPPER = 1'b0, SB_LOWER = 1'b1} sideband_e;

  // Magnitude of quarter-table entry k, sampled at the centre of its bin.
  function automatic int unsigned quarter_mag(int k, int tbl_bits, int amp, bit use_cos);
    real ang;
    real v;
    ang = 1.5707963267948966 * (real'(k) + 0.5) / real'(1 << tbl_bits);
    v   = use_cos ? $cos(ang) : $sin(ang);
    return $rtoi(real'(amp) * v + 0.5);
  endfunction

  // Table index is read reversed in quadrants 1 and 3 for both waves.
  function automatic logic quad_mirror(logic [1:0] quad);
    return quad[0];
  endfunction

  // Sine is negative in quadrants 2,3; cosine in quadrants 1,2.
  function automatic logic quad_negate(logic [1:0] quad, bit use_cos);
    return use_cos ? (quad[1] ^ quad[0]) : quad[1];
  endfunction

endpackage

// File: rtl/quad_dds_csel_add.sv
module quad_dds_csel_add #(
  parameter int W    = 11,
  parameter int LO_W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  generate
    if (LO_W >= W || LO_W < 1) begin : g_plain
      assign sum = a + b;
    end else begin : g_split
      localparam int HI_W = W - LO_W;
      logic [LO_W-1:0] lo_sum;
      logic            lo_carry;
      logic [HI_W-1:0] hi_c0;
      logic [HI_W-1:0] hi_c1;
      assign {lo_carry, lo_sum} = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
      // Both upper results are ready before the low carry settles.
      assign hi_c0 = a[W-1:LO_W] + b[W-1:LO_W];
      assign hi_c1 = a[W-1:LO_W] + b[W-1:LO_W] + HI_W'(1);
      assign sum   = {lo_carry ? hi_c1 : hi_c0, lo_sum};
    end
  endgenerate

  // R3
  always_comb begin
    csel_sum_chk: assert (sum == W'(a + b))
      else $error("carry-select sum mismatch");
  end
endmodule

// File: rtl/quad_dds_phase_acc.sv
module quad_dds_phase_acc #(
  parameter int PHASE_W = 11,
  parameter int LO_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PHASE_W-1:0] fcw_in,
  output logic [PHASE_W-1:0] phase,
  output logic [PHASE_W-1:0] fcw_q
);
  logic [PHASE_W-1:0] phase_nxt;

  quad_dds_csel_add #(.W(PHASE_W), .LO_W(LO_W)) u_add (
    .a  (phase),
    .b  (fcw_q),
    .sum(phase_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fcw_q <= '0;
      phase <= '0;
    end else begin
      if (load) fcw_q <= fcw_in;
      phase <= phase_nxt;
    end
  end

  // R2
  fcw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(fcw_q))
    else $error("tuning word changed without strobe");

  // R2
  fcw_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> (fcw_q == $past(fcw_in)))
    else $error("tuning word not captured");

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phase == PHASE_W'($past(phase) + $past(fcw_q))))
    else $error("phase step wrong");
endmodule

// File: rtl/quad_dds_qrom.sv
module quad_dds_qrom #(
  parameter int TBL_BITS = 7,
  parameter int OUT_W    = 10,
  parameter bit USE_COS  = 1'b0
) (
  input  logic [TBL_BITS+1:0]      addr,
  output logic signed [OUT_W-1:0]  val
);
  import quad_dds_pkg::*;

  localparam int DEPTH = 1 << TBL_BITS;
  localparam int MAG_W = OUT_W - 1;
  localparam int AMP   = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] tbl [DEPTH];

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
      localparam int unsigned MAG = quarter_mag(k, TBL_BITS, AMP, USE_COS);
      assign tbl[k] = MAG_W'(MAG);
    end
  endgenerate

  logic [1:0]          quad;
  logic [TBL_BITS-1:0] idx;
  logic [TBL_BITS-1:0] rd_idx;
  logic                mirror_ev;
  logic                negate_ev;
  logic [MAG_W-1:0]    mag;

  assign quad      = addr[TBL_BITS+1:TBL_BITS];
  assign idx       = addr[TBL_BITS-1:0];
  assign mirror_ev = quad_mirror(quad);
  assign negate_ev = quad_negate(quad, USE_COS);
  assign rd_idx    = mirror_ev ? ~idx : idx;
  assign mag       = tbl[rd_idx];
  assign val       = negate_ev ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  // R9
  always_comb begin
    rom_range_chk: assert (val != {1'b1, {MAG_W{1'b0}}})
      else $error("table output at negative full scale");
  end
endmodule

// File: rtl/quad_dds.sv
module quad_dds #(
  parameter int PHASE_W   = 11,
  parameter int OUT_W     = 10,
  parameter int TBL_BITS  = 7,
  parameter int CSEL_LO_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fcw_load,
  input  logic [PHASE_W-1:0] fcw_in,
  input  logic               sb_lower,
  output logic [OUT_W-1:0]   i_out,
  output logic [OUT_W-1:0]   q_out
);
  import quad_dds_pkg::*;

  localparam int ADDR_W = TBL_BITS + 2;

  logic [PHASE_W-1:0]      phase;
  logic [PHASE_W-1:0]      fcw_q;
  logic [ADDR_W-1:0]       rom_addr;
  logic signed [OUT_W-1:0] sin_val;
  logic signed [OUT_W-1:0] cos_val;
  logic signed [OUT_W-1:0] q_nxt;
  sideband_e               sb_sel;

  quad_dds_phase_acc #(.PHASE_W(PHASE_W), .LO_W(CSEL_LO_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .load  (fcw_load),
    .fcw_in(fcw_in),
    .phase (phase),
    .fcw_q (fcw_q)
  );

  assign rom_addr = phase[PHASE_W-1 -: ADDR_W];

  generate
    if (PHASE_W > ADDR_W) begin : g_trunc
      logic unused_phase_lsbs;
      assign unused_phase_lsbs = ^{phase[PHASE_W-ADDR_W-1:0], fcw_q};
    end else begin : g_full
      logic unused_fcw;
      assign unused_fcw = ^fcw_q;
    end
  endgenerate

  quad_dds_qrom #(.TBL_BITS(TBL_BITS), .OUT_W(OUT_W), .USE_COS(1'b0)) u_sin (
    .addr(rom_addr),
    .val (sin_val)
  );

  quad_dds_qrom #(.TBL_BITS(TBL_BITS), .OUT_W(OUT_W), .USE_COS(1'b1)) u_cos (
    .addr(rom_addr),
    .val (cos_val)
  );

  assign sb_sel = sideband_e'(sb_lower);
  assign q_nxt  = (sb_sel == SB_LOWER) ? -cos_val : cos_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      i_out <= '0;
      q_out <= '0;
    end else begin
      i_out <= sin_val;
      q_out <= q_nxt;
    end
  end

  // R4
  i_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($signed(i_out) == $past(sin_val)))
    else $error("I output does not follow sine table");

  // R5
  q_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sb_lower)) |-> ($signed(q_out) == $past(cos_val)))
    else $error("Q output wrong in upper sideband");

  // R6
  q_lower_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sb_lower)) |-> ($signed(q_out) == -$past(cos_val)))
    else $error("Q output not negated in lower sideband");

  // R3
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fcw_load) && (fcw_q == '0)) |-> $stable(phase))
    else $error("phase moved with zero word");
endmodule

// File: tb/quad_dds_bench.sv
module quad_dds_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fcw_load = 1'b0;
  logic [10:0] fcw_in = '0;
  logic        sb_lower = 1'b0;
  logic [9:0]  i_out;
  logic [9:0]  q_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  quad_dds u_quad_dds (
    .clk(clk), .rst(rst), .fcw_load(fcw_load), .fcw_in(fcw_in),
    .sb_lower(sb_lower), .i_out(i_out), .q_out(q_out)
  );

  // Reference sample for 9-bit phase index p (R4, R5).
  function automatic int ref_wave(int p, bit use_cos);
    real a;
    real v;
    a = 6.283185307179586 * (real'(p) + 0.5) / 512.0;
    v = 511.0 * (use_cos ? $cos(a) : $sin(a));
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  // Behavioural model built from the requirements.
  logic [10:0] m_word;
  logic [10:0] m_phase;
  int          e_i;
  int          e_q;
  always @(posedge clk) begin
    if (rst) begin
      m_word  <= '0;
      m_phase <= '0;
      e_i     <= 0;
      e_q     <= 0;
    end else begin
      if (fcw_load) m_word <= fcw_in;
      m_phase <= m_phase + m_word;
      e_i <= ref_wave(int'(m_phase[10:2]), 1'b0);
      e_q <= sb_lower ? -ref_wave(int'(m_phase[10:2]), 1'b1)
                      :  ref_wave(int'(m_phase[10:2]), 1'b1);
    end
  end

  task automatic check_val(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check_val({tag, " I"}, int'($signed(i_out)), e_i);
    check_val({tag, " Q"}, int'($signed(q_out)), e_q);
    if ($signed(i_out) == -512 || $signed(q_out) == -512) begin
      fails++;
      $display("FAIL R9: actual %0d/%0d expected above -512",
               $signed(i_out), $signed(q_out));
    end
  endtask

  task automatic step(bit ld, logic [10:0] w, bit sb);
    fcw_load = ld; fcw_in = w; sb_lower = sb;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    fcw_in = 11'h5a5; fcw_load = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R1 reset I", int'($signed(i_out)), 0);
    check_val("R1 reset Q", int'($signed(q_out)), 0);
    fcw_load = 1'b0;
    rst = 1'b0;
    // Word 0 after reset: phase stays 0, sample of index 0.
    step(0, 11'h7ff, 0);
    step(0, 11'h123, 0);
    check_val("R1 first I", int'($signed(i_out)), ref_wave(0, 1'b0));
    check_val("R1 first Q", int'($signed(q_out)), ref_wave(0, 1'b1));
  endtask

  task automatic t_latency();
    // Load 512 (quarter turn) at edge E.
    step(1, 11'd512, 0);         // edge E: word stored
    step(0, 11'd0, 0);           // E+1: phase 0 -> 512, output of phase 0
    check_val("R7 no early effect I", int'($signed(i_out)), ref_wave(0, 1'b0));
    step(0, 11'd0, 0);           // E+2: output of phase 512
    check_val("R7 first effect I", int'($signed(i_out)), ref_wave(128, 1'b0));
    check_val("R7 first effect Q", int'($signed(q_out)), ref_wave(128, 1'b1));
    step(0, 11'd0, 0);
    check_val("R7 half turn I", int'($signed(i_out)), ref_wave(256, 1'b0));
    check_outs("R7");
  endtask

  task automatic t_sweep(logic [10:0] w, int n, string tag);
    step(1, w, 0);
    for (int k = 0; k < n; k++) begin
      step(0, 11'd0, 0);
      check_outs(tag);
    end
  endtask

  task automatic t_ignore();
    step(1, 11'd9, 0);
    for (int k = 0; k < 60; k++) begin
      step(0, 11'((k * 173) ^ 11'h2aa), 0);
      check_outs("R2 unstrobed word");
    end
  endtask

  task automatic t_sideband();
    step(1, 11'd37, 0);
    for (int k = 0; k < 80; k++) begin
      step(0, 11'd0, k[0]);
      check_outs("R6 sideband");
    end
  endtask

  task automatic t_hop();
    for (int h = 0; h < 12; h++) begin
      step(1, 11'((h * 311 + 5) & 11'h7ff), h[1]);
      check_outs("R8 hop");
      for (int k = 0; k < 6; k++) begin
        step(0, 11'd0, h[1]);
        check_outs("R8 hop");
      end
    end
  endtask

  task automatic t_freeze();
    int held_i;
    int held_q;
    step(1, 11'd0, 0);
    step(0, 11'd0, 0);
    step(0, 11'd0, 0);
    held_i = int'($signed(i_out));
    held_q = int'($signed(q_out));
    for (int k = 0; k < 10; k++) begin
      step(0, 11'h3ff, 0);
      check_val("R3 freeze I", int'($signed(i_out)), held_i);
      check_val("R3 freeze Q", int'($signed(q_out)), held_q);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_sweep(11'd1, 2100, "R4 R5 R3 slow sweep");
    t_sweep(11'd2047, 40, "R3 backward wrap");
    t_sweep(11'd1021, 60, "R4 coarse step");
    t_ignore();
    t_sideband();
    t_hop();
    t_freeze();
    t_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule